// File: doc/BRIEF.md
# Rotating-Priority Shared Bus Arbiter

This block decides which agent may drive a shared external bus. Up to eight peer processors and one host each present a request line and receive a grant line. Among the processors, the search for the next owner starts just after the agent that owned the bus most recently, so that owner becomes the lowest priority. The host is served ahead of any processor whenever ownership changes hands. A configuration input marks which processor slots are populated, and requests from empty slots are never honoured.

An owner can assert a lock input to keep the bus across an indivisible read-modify-write sequence. While lock is high the grant cannot move for any reason. A programmable fairness limit counts the bus cycles of a processor's tenure. Once the limit is reached and another agent is waiting, the owner is released at its next transaction boundary, which is signalled by a done strobe. Each change of owner passes through exactly one cycle in which no grant is asserted. The real system spreads this logic across all the agents; here it is modelled as one centralized synchronous module.

Top module: `rr_bus_arbiter`

## Requirements
- R1: At most one of the `N_PROC+1` grant outputs (`proc_gnt` bits and `host_gnt`) is high in any cycle.
- R2: When a grant drops, the next grant appears no earlier than one full cycle later, and a request seen while the bus is idle is granted at the next clock edge, so a handover leaves exactly one idle cycle.
- R3: Processor arbitration searches indices in increasing order, wrapping around, starting one above the most recent processor owner. After reset the search starts at index 0.
- R4: A processor whose bit in `present_mask` is 0 is never granted, even if its request is high.
- R5: A processor owner whose request drops while `lock` is low loses its grant at the next clock edge, whatever `xfer_done` is.
- R6: While a processor owner holds `lock` high, its grant stays put even if its request drops, the host requests, or the fairness limit has expired.
- R7: A processor owner that keeps requesting with `xfer_done` held high, while another present processor requests and the host does not, holds the grant for exactly `fair_limit+1` cycles.
- R8: When no other present processor and no host is requesting, a processor owner keeps the bus after its fairness limit has expired.
- R9: When the host requests, the processor owner is released at its next `xfer_done` with lock low. The host then wins the next arbitration over any processor, including the case where the host and a processor request together from idle.
- R10: The host keeps its grant for as long as `host_req` stays high, and releases it at the clock edge after `host_req` drops.
- R11: A processor owner that still requests is never released in a cycle where `xfer_done` is low.
- R12: While `rst_n` is low, all grants are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| present_mask | input | N_PROC | 1 marks a populated processor slot |
| fair_limit | input | CNT_W | Tenure cycles counted before fairness may force release |
| proc_req | input | N_PROC | Per-processor bus request |
| host_req | input | 1 | Host bus request |
| lock | input | 1 | Current owner holds the bus for an atomic sequence |
| xfer_done | input | 1 | Current owner is at a transaction boundary |
| proc_gnt | output | N_PROC | One-hot processor grant |
| host_gnt | output | 1 | Host grant |

## Verification
The bench sweeps every `present_mask` value of a four-processor build with all requests high and a fairness limit of zero. This forces a handover every other cycle and compares the whole grant order against a rotation model. A design that restarted the search at index 0 would starve the upper agents, and one that ignored the mask would grant empty slots. The fairness limit is swept over a range and the tenure length is counted, which catches off-by-one errors in the counter and any release that skips the idle turnaround cycle. Separate sequences drop a request under lock, hold `xfer_done` low, let a lone owner outlive its limit, and race the host against processors. These expose a lock that fairness can break, a release taken in the middle of a transaction, and a host that a processor can preempt.

// File: rtl/rr_arb_pkg.sv
// Shared types for the rotating-priority bus arbiter.
// Assumes: only the arbiter and its helpers import it.
package rr_arb_pkg;

    // Kind of agent that currently owns the bus.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_PROC = 2'd1,
        OWN_HOST = 2'd2
    } own_kind_e;

endpackage

// File: rtl/rr_arb_pick.sv
// Round-robin picker: returns the first set request bit found by searching
// upward from one above 'last', wrapping around at N_PROC.
// Assumes: purely combinational, 'req' is already masked by presence.
module rr_arb_pick #(
    parameter int N_PROC = 8,
    parameter int IDX_W  = 3
) (
    input  logic [N_PROC-1:0] req,
    input  logic [IDX_W-1:0]  last,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    // Scan the candidates in rotated order and keep the first hit.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 1; k <= N_PROC; k++) begin : scan
            int pos;
            pos = (int'(last) + k) % N_PROC;
            if (!hit && req[pos]) begin
                hit = 1'b1;
                idx = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/rr_arb_fair_timer.sv
// Tenure counter for fairness: cleared while the bus has no owner, counts
// each cycle a processor owns the bus, saturates at all-ones.
// Assumes: 'restart' and 'run' are never both high.
module rr_arb_fair_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] tenure_q;

    // Count owned cycles, clear between owners.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tenure_q <= '0;
        end else if (restart) begin
            tenure_q <= '0;
        end else if (run && (tenure_q != '1)) begin
            tenure_q <= tenure_q + 1'b1;
        end
    end

    // Limit reached once the counted tenure meets the programmed value.
    always_comb begin
        expired = (tenure_q >= limit);
    end

endmodule

// File: rtl/rr_arb_grant_dec.sv
// Turns the registered owner index into a one-hot processor grant vector.
// Assumes: 'idx' < N_PROC whenever 'en' is high.
module rr_arb_grant_dec #(
    parameter int N_PROC = 8,
    parameter int IDX_W  = 3
) (
    input  logic              en,
    input  logic [IDX_W-1:0]  idx,
    output logic [N_PROC-1:0] gnt
);

    // One comparator per processor slot.
    for (genvar g = 0; g < N_PROC; g++) begin : g_slot
        assign gnt[g] = en && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/rr_bus_arbiter.sv
// Centralized model of a distributed rotating-priority bus arbiter for up to
// N_PROC processors and one host. Grants are registered. Every handover goes
// through one idle cycle. Lock freezes the owner. A tenure counter forces a
// contended processor owner off the bus at a transaction boundary.
// Assumes: 'lock' and 'xfer_done' come from the current owner.
module rr_bus_arbiter
    import rr_arb_pkg::*;
#(
    parameter int N_PROC = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PROC-1:0] present_mask,
    input  logic [CNT_W-1:0]  fair_limit,
    input  logic [N_PROC-1:0] proc_req,
    input  logic              host_req,
    input  logic              lock,
    input  logic              xfer_done,
    output logic [N_PROC-1:0] proc_gnt,
    output logic              host_gnt
);

    localparam int IDX_W = (N_PROC > 1) ? $clog2(N_PROC) : 1;

    own_kind_e         kind_q;
    logic [IDX_W-1:0]  owner_q;
    logic [IDX_W-1:0]  last_q;
    logic [N_PROC-1:0] eligible;
    logic              pick_hit;
    logic [IDX_W-1:0]  pick_idx;
    logic              fair_expired;
    logic              owner_req;
    logic              contend;
    logic              proc_release;
    logic              release_now;

    // Presence filter on processor requests.
    always_comb begin
        eligible = proc_req & present_mask;
    end

    rr_arb_pick #(.N_PROC(N_PROC), .IDX_W(IDX_W)) pick_i (
        .req  (eligible),
        .last (last_q),
        .hit  (pick_hit),
        .idx  (pick_idx)
    );

    rr_arb_fair_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (kind_q == OWN_NONE),
        .run     (kind_q == OWN_PROC),
        .limit   (fair_limit),
        .expired (fair_expired)
    );

    rr_arb_grant_dec #(.N_PROC(N_PROC), .IDX_W(IDX_W)) dec_i (
        .en  (kind_q == OWN_PROC),
        .idx (owner_q),
        .gnt (proc_gnt)
    );

    // Host grant is a direct decode of the owner kind.
    always_comb begin
        host_gnt = (kind_q == OWN_HOST);
    end

    // Release conditions for the current owner.
    always_comb begin
        owner_req    = proc_req[owner_q];
        contend      = host_req || ((eligible & ~proc_gnt) != '0);
        proc_release = !lock &&
                       (!owner_req ||
                        (xfer_done && (host_req || (fair_expired && contend))));
        unique case (kind_q)
            OWN_PROC: release_now = proc_release;
            OWN_HOST: release_now = !host_req;
            default:  release_now = 1'b0;
        endcase
    end

    // Ownership state: release to idle, or pick a new owner from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= OWN_NONE;
            owner_q <= '0;
            last_q  <= IDX_W'(N_PROC - 1);
        end else if (kind_q != OWN_NONE) begin
            if (release_now) begin
                kind_q <= OWN_NONE;
            end
        end else if (host_req) begin
            kind_q <= OWN_HOST;
        end else if (pick_hit) begin
            kind_q  <= OWN_PROC;
            owner_q <= pick_idx;
            last_q  <= pick_idx;
        end
    end

endmodule

// File: rtl/rr_bus_arbiter_chk.sv
// Property checker for rr_bus_arbiter, attached to every instance by bind.
// Assumes: observes only the arbiter's ports.
module rr_bus_arbiter_chk #(
    parameter int N_PROC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PROC-1:0] present_mask,
    input logic [N_PROC-1:0] proc_req,
    input logic              host_req,
    input logic              lock,
    input logic              xfer_done,
    input logic [N_PROC-1:0] proc_gnt,
    input logic              host_gnt
);

    logic [N_PROC:0] all_gnt;

    // Gather every grant into one vector.
    always_comb begin
        all_gnt = {host_gnt, proc_gnt};
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(all_gnt)); // R1

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (all_gnt != '0) |=> (all_gnt == '0 || all_gnt == $past(all_gnt))); // R2

    AST_GRANT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_gnt != '0 && $past(all_gnt) == '0) |->
        ((proc_gnt & $past(proc_req & present_mask)) == proc_gnt)); // R4

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_gnt != '0 && (proc_gnt & proc_req) == '0 && !lock) |=>
        (proc_gnt == '0)); // R5

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_gnt != '0 && lock) |=> (proc_gnt == $past(proc_gnt))); // R6

    AST_HOST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && host_req) |=> host_gnt); // R10

    AST_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_gnt != '0 && (proc_gnt & proc_req) != '0 && !xfer_done) |=>
        (proc_gnt == $past(proc_gnt))); // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> all_gnt == '0)); // R12

endmodule

bind rr_bus_arbiter rr_bus_arbiter_chk #(.N_PROC(N_PROC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .present_mask (present_mask),
    .proc_req     (proc_req),
    .host_req     (host_req),
    .lock         (lock),
    .xfer_done    (xfer_done),
    .proc_gnt     (proc_gnt),
    .host_gnt     (host_gnt)
);

// File: tb/rr_bus_arbiter_tb_top.sv
// Self-checking bench: four-processor build, mask sweep, fairness sweep and
// directed lock, host and boundary sequences.
module rr_bus_arbiter_tb_top;

    localparam int NP = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] present_mask = '1;
    logic [CW-1:0] fair_limit = '0;
    logic [NP-1:0] proc_req = '0;
    logic          host_req = 1'b0;
    logic          lock = 1'b0;
    logic          xfer_done = 1'b0;
    logic [NP-1:0] proc_gnt;
    logic          host_gnt;

    int n_chk  = 0;
    int n_fail = 0;

    rr_bus_arbiter #(.N_PROC(NP), .CNT_W(CW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .present_mask (present_mask),
        .fair_limit   (fair_limit),
        .proc_req     (proc_req),
        .host_req     (host_req),
        .lock         (lock),
        .xfer_done    (xfer_done),
        .proc_gnt     (proc_gnt),
        .host_gnt     (host_gnt)
    );

    // 250 MHz clock.
    always #2ns clk = ~clk;

    // Record one check and report it if it failed.
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance past the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1ns;
    endtask

    // Hold reset for two edges with the current inputs, then release it.
    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R12: grants stay low under reset even with requests present.
        proc_req = '1;
        host_req = 1'b1;
        rst_n    = 1'b0;
        repeat (3) tick();
        chk(proc_gnt == '0 && host_gnt == 1'b0, "R12 reset quiet",
            int'({host_gnt, proc_gnt}), 0);
        host_req = 1'b0;

        // R3 R4 R1 R8: sweep every presence mask with all requests high.
        for (int m = 0; m < (1 << NP); m++) begin
            int pc;
            int exp_own;
            int exp_last;
            int exp_vec;
            pc = 0;
            for (int b = 0; b < NP; b++) if (m[b]) pc++;
            present_mask = NP'(m);
            proc_req     = '1;
            fair_limit   = '0;
            xfer_done    = 1'b1;
            lock         = 1'b0;
            host_req     = 1'b0;
            do_reset();
            exp_own  = -1;
            exp_last = NP - 1;
            for (int c = 0; c < 20; c++) begin
                tick();
                if (exp_own < 0) begin
                    for (int k = 1; k <= NP; k++) begin
                        int p;
                        p = (exp_last + k) % NP;
                        if (exp_own < 0 && m[p]) begin
                            exp_own  = p;
                            exp_last = p;
                        end
                    end
                end else if (pc > 1) begin
                    exp_own = -1;
                end
                exp_vec = (exp_own < 0) ? 0 : (1 << exp_own);
                chk(int'(proc_gnt) == exp_vec && !host_gnt, "R3 R4 R8 rotation order",
                    int'(proc_gnt), exp_vec);
                chk($countones({host_gnt, proc_gnt}) <= 1, "R1 single grant",
                    $countones({host_gnt, proc_gnt}), 1);
            end
        end

        // R7 R2: tenure length under contention equals limit plus one.
        present_mask = '1;
        for (int lim = 0; lim < 6; lim++) begin
            int held;
            proc_req   = 4'b0011;
            fair_limit = CW'(lim);
            xfer_done  = 1'b1;
            do_reset();
            tick();
            held = 0;
            while (proc_gnt == 4'b0001 && held < 40) begin
                held++;
                tick();
            end
            chk(held == lim + 1, "R7 fairness tenure", held, lim + 1);
            chk(proc_gnt == '0 && !host_gnt, "R2 idle turnaround", int'(proc_gnt), 0);
            tick();
            chk(proc_gnt == 4'b0010, "R3 next after turnaround", int'(proc_gnt), 2);
        end

        // R8: lone requester outlives its limit.
        proc_req   = 4'b0001;
        fair_limit = '0;
        xfer_done  = 1'b1;
        do_reset();
        repeat (11) tick();
        chk(proc_gnt == 4'b0001, "R8 lone owner keeps bus", int'(proc_gnt), 1);

        // R11: no release while the transaction is open.
        proc_req  = 4'b0011;
        xfer_done = 1'b0;
        do_reset();
        tick();
        repeat (6) tick();
        chk(proc_gnt == 4'b0001, "R11 hold until boundary", int'(proc_gnt), 1);
        xfer_done = 1'b1;
        tick();
        chk(proc_gnt == '0, "R11 release at boundary", int'(proc_gnt), 0);
        tick();
        chk(proc_gnt == 4'b0010, "R2 regrant after one idle cycle", int'(proc_gnt), 2);

        // R5: dropping the request releases even mid-transaction.
        proc_req  = 4'b0001;
        xfer_done = 1'b0;
        do_reset();
        tick();
        tick();
        chk(proc_gnt == 4'b0001, "R5 owner before drop", int'(proc_gnt), 1);
        proc_req = '0;
        tick();
        chk(proc_gnt == '0, "R5 release on request drop", int'(proc_gnt), 0);

        // R6 R9: lock beats request drop, host and fairness; host wins after.
        proc_req   = 4'b0011;
        fair_limit = '0;
        xfer_done  = 1'b1;
        lock       = 1'b0;
        do_reset();
        lock = 1'b1;
        tick();
        chk(proc_gnt == 4'b0001, "R6 owner before lock test", int'(proc_gnt), 1);
        host_req = 1'b1;
        proc_req = 4'b0010;
        repeat (5) tick();
        chk(proc_gnt == 4'b0001 && !host_gnt, "R6 lock holds grant",
            int'({host_gnt, proc_gnt}), 1);
        lock = 1'b0;
        tick();
        chk(proc_gnt == '0 && !host_gnt, "R9 release for host",
            int'({host_gnt, proc_gnt}), 0);
        tick();
        chk(host_gnt && proc_gnt == '0, "R9 host wins handover",
            int'({host_gnt, proc_gnt}), 16);

        // R10: host keeps the bus while requesting, then processor 1 follows.
        proc_req = 4'b0011;
        repeat (5) tick();
        chk(host_gnt && proc_gnt == '0, "R10 host keeps bus",
            int'({host_gnt, proc_gnt}), 16);
        host_req = 1'b0;
        tick();
        chk(!host_gnt && proc_gnt == '0, "R10 host release",
            int'({host_gnt, proc_gnt}), 0);
        tick();
        chk(proc_gnt == 4'b0010, "R3 rotation resumes after host", int'(proc_gnt), 2);

        // R9: host and processor request together from idle.
        proc_req = 4'b0001;
        host_req = 1'b1;
        do_reset();
        tick();
        chk(host_gnt && proc_gnt == '0, "R9 host first from idle",
            int'({host_gnt, proc_gnt}), 16);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule